// File: doc/BRIEF.md
# Serial Peripheral Master with Gapless Word Chaining

This block is a serial peripheral master. It generates the serial clock, shifts words out on the data-out line and captures the data-in line, and can drive an active-low select output. It always uses clock phase 1 with the clock idling low. Software writes a word, tagged as 8 or 16 bits, into a single-entry holding register. The engine moves that word into its shifter as soon as the shifter is free.

When a word finishes and another word is already waiting, the engine starts the new word at the same instant as the completion pulse, exactly one half clock period after the last falling edge. No trailing delay or idle gap is inserted, and the select line stays low. A leading delay of one half period comes before the first rising edge only when a burst starts from idle. When nothing is waiting, the clock stops low and the select line is released together with the completion pulse.

Top module: `spim_chain_master`

## Requirements
- R1: After reset, sck_o and xfer_done_o are 0, ss_n_o and tx_empty_o are 1, and busy_o is 0.
- R2: Every serial clock edge is spaced by half_div_i system clocks, with 0 treated as 1. sck_o is low whenever busy_o is low.
- R3: Bits go out MSB first. mosi_o takes each new bit on a rising sck_o edge, and miso_i is captured on each falling edge.
- R4: wr_wide_i=1 sends a 16-bit word, and wr_wide_i=0 sends wr_data_i[7:0]. The width is stored with the word at write time. For 8-bit words, rd_data_o[15:8] reads 0.
- R5: With ss_en_i=1, ss_n_o is low from the load of a burst's first word until the burst ends. With ss_en_i=0, ss_n_o stays high.
- R6: At the start of a burst from idle, the first rising edge comes half_div_i clocks after busy_o rises (the word load).
- R7: xfer_done_o is a one-cycle pulse, half_div_i clocks after the final falling edge of a word. rd_data_o holds the received word from that cycle on.
- R8: If a word is waiting when xfer_done_o pulses, the next word's first rising edge occurs in that same cycle and ss_n_o stays low.
- R9: An accepted write clears tx_empty_o. tx_empty_o sets again when the word moves into the shifter.
- R10: A write while tx_empty_o=0 is ignored, and the waiting word is sent unchanged.
- R11: If no word is waiting when xfer_done_o pulses, sck_o stays low, and busy_o falls and ss_n_o rises in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_div_i | input | DIV_W | Serial clock half period in system clocks |
| ss_en_i | input | 1 | Enable driving of the select output |
| wr_valid_i | input | 1 | Write strobe for the holding register |
| wr_wide_i | input | 1 | Width of the written word (1 = 16 bits) |
| wr_data_i | input | WORD_W | Word to transmit |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| ss_n_o | output | 1 | Active-low select |
| tx_empty_o | output | 1 | Holding register empty |
| xfer_done_o | output | 1 | Word complete pulse |
| rd_data_o | output | WORD_W | Last received word |
| busy_o | output | 1 | Engine active |

## Verification
The assertions check on every cycle the following properties:
- the serial clock moves only on divider ticks and stays low when idle;
- the completion pulse lasts one cycle;
- a chained word shows its rising edge together with the pulse;
- the select line is high whenever it is disabled;
- the holding register is emptied only by a load and keeps its contents against writes while full.

Only the bench scenarios can show that edge spacing, the leading delay and the completion delay all equal the programmed divider. The same holds for bit order and content in both widths, and for the fact that an ignored write never reaches the line.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_TAIL  = 2'd3
   } spim_state_e;
endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] half_div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   // a zero divider behaves as one
   assign lim    = (half_div_i == '0) ? '0 : half_div_i - 1'b1;
   assign tick_o = run_i && (cnt_q >= lim);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (!run_i || tick_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   // R2: the counter never runs while the engine is idle
   assert_idle_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> cnt_q == '0);
endmodule

// File: rtl/spim_txbuf.sv
module spim_txbuf #(
   parameter int WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic              wide_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              take_i,
   output logic [WORD_W-1:0] data_o,
   output logic              wide_o,
   output logic              empty_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         empty_o <= 1'b1;
         data_o  <= '0;
         wide_o  <= 1'b0;
      end else if (take_i) begin
         empty_o <= 1'b1;
      end else if (wr_i && empty_o) begin
         data_o  <= wdata_i;
         wide_o  <= wide_i;
         empty_o <= 1'b0;
      end
   end

   assert_empty_by_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(empty_o) |-> $past(take_i));
   assert_take_needs_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |-> !empty_o);
   assert_keep_when_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !empty_o) |=> ($stable(data_o) && $stable(wide_o)));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int WORD_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              wide_i,
   input  logic [WORD_W-1:0] load_data_i,
   input  logic              lead_i,
   input  logic              trail_i,
   input  logic              miso_i,
   output logic              mosi_o,
   output logic              wide_o,
   output logic [WORD_W-1:0] rx_o
);
   localparam int PAD_W = WORD_W - NARROW_W;

   logic [WORD_W-1:0] tx_q, rx_q, aligned, src;

   // narrow words are left-aligned so the MSB always leaves from the top bit
   assign aligned = wide_i ? load_data_i : {load_data_i[NARROW_W-1:0], {PAD_W{1'b0}}};
   assign src     = load_i ? aligned : tx_q;
   assign rx_o    = wide_o ? rx_q : {{PAD_W{1'b0}}, rx_q[NARROW_W-1:0]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_q   <= '0;
         rx_q   <= '0;
         mosi_o <= 1'b0;
         wide_o <= 1'b0;
      end else begin
         if (load_i) begin
            wide_o <= wide_i;
            rx_q   <= '0;
         end
         if (lead_i) begin
            mosi_o <= src[WORD_W-1];
            tx_q   <= {src[WORD_W-2:0], 1'b0};
         end else if (load_i) begin
            tx_q   <= aligned;
         end
         if (trail_i) rx_q <= {rx_q[WORD_W-2:0], miso_i};
      end
   end

   assert_mosi_on_lead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(mosi_o) |-> $past(lead_i));
   assert_edges_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lead_i && trail_i));
endmodule

// File: rtl/spim_chain_master.sv
module spim_chain_master #(
   parameter int DIV_W    = 8,
   parameter int WORD_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DIV_W-1:0]  half_div_i,
   input  logic              ss_en_i,
   input  logic              wr_valid_i,
   input  logic              wr_wide_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              miso_i,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              ss_n_o,
   output logic              tx_empty_o,
   output logic              xfer_done_o,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              busy_o
);
   import spim_pkg::*;

   localparam int ECNT_W = $clog2(2*WORD_W + 1);
   localparam logic [ECNT_W-1:0] LAST_WIDE   = ECNT_W'(2*WORD_W - 1);
   localparam logic [ECNT_W-1:0] LAST_NARROW = ECNT_W'(2*NARROW_W - 1);

   initial begin
      assert (WORD_W > NARROW_W) else $error("WORD_W must exceed NARROW_W");
      assert (NARROW_W >= 2)     else $error("NARROW_W too small");
      assert (DIV_W >= 1)        else $error("DIV_W too small");
   end

   spim_state_e state_q, state_d;
   logic [ECNT_W-1:0] ecnt_q;
   logic tick, load, lead, trail, run, wide_q, buf_wide;
   logic [WORD_W-1:0] buf_data, rx_word;

   assign run    = (state_q != ST_IDLE);
   assign busy_o = run;

   spim_tick #(.DIV_W(DIV_W)) u_tick (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
      .half_div_i(half_div_i), .tick_o(tick));

   spim_txbuf #(.WORD_W(WORD_W)) u_buf (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_valid_i), .wide_i(wr_wide_i),
      .wdata_i(wr_data_i), .take_i(load), .data_o(buf_data),
      .wide_o(buf_wide), .empty_o(tx_empty_o));

   spim_shifter #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .wide_i(buf_wide),
      .load_data_i(buf_data), .lead_i(lead), .trail_i(trail),
      .miso_i(miso_i), .mosi_o(mosi_o), .wide_o(wide_q), .rx_o(rx_word));

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      lead    = 1'b0;
      trail   = 1'b0;
      unique case (state_q)
         ST_IDLE: if (!tx_empty_o) begin
            load    = 1'b1;
            state_d = ST_LEAD;
         end
         ST_LEAD: if (tick) begin
            lead    = 1'b1;
            state_d = ST_SHIFT;
         end
         ST_SHIFT: if (tick) begin
            if (sck_o) begin
               trail = 1'b1;
               if (ecnt_q == (wide_q ? LAST_WIDE : LAST_NARROW)) state_d = ST_TAIL;
            end else begin
               lead = 1'b1;
            end
         end
         ST_TAIL: if (tick) begin
            if (!tx_empty_o) begin
               // chained word: first rising edge coincides with completion
               load    = 1'b1;
               lead    = 1'b1;
               state_d = ST_SHIFT;
            end else begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         ecnt_q      <= '0;
         sck_o       <= 1'b0;
         ss_n_o      <= 1'b1;
         xfer_done_o <= 1'b0;
         rd_data_o   <= '0;
      end else begin
         state_q     <= state_d;
         ss_n_o      <= !((state_d != ST_IDLE) && ss_en_i);
         xfer_done_o <= (state_q == ST_TAIL) && tick;
         if ((state_q == ST_TAIL) && tick) rd_data_o <= rx_word;
         if (lead)       sck_o <= 1'b1;
         else if (trail) sck_o <= 1'b0;
         if (load)                ecnt_q <= lead ? ECNT_W'(1) : '0;
         else if (lead || trail)  ecnt_q <= ecnt_q + 1'b1;
      end
   end

   assert_sck_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sck_o) |-> $past(tick));
   assert_sck_low_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !sck_o);
   assert_ss_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ss_en_i |=> ss_n_o);
   assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_done_o |=> !xfer_done_o);
   assert_chain_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xfer_done_o && busy_o) |-> sck_o);
   assert_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xfer_done_o && !busy_o) |-> (ss_n_o && !sck_o));
endmodule

// File: tb/spim_chain_master_tb.sv
module spim_chain_master_tb;
   typedef struct packed {
      logic        w;
      logic [15:0] d;
      logic [15:0] sw;
   } ent_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] half_div = 8'd2;
   logic ss_en = 1'b1, wr_valid = 1'b0, wr_wide = 1'b0, miso = 1'b0;
   logic [15:0] wr_data = '0;
   logic sck, mosi, ss_n, tx_empty, done, busy;
   logic [15:0] rd_data;

   always #4 clk = ~clk;

   spim_chain_master u_dut (
      .clk_i(clk), .rst_ni(rst_n), .half_div_i(half_div), .ss_en_i(ss_en),
      .wr_valid_i(wr_valid), .wr_wide_i(wr_wide), .wr_data_i(wr_data),
      .miso_i(miso), .sck_o(sck), .mosi_o(mosi), .ss_n_o(ss_n),
      .tx_empty_o(tx_empty), .xfer_done_o(done), .rd_data_o(rd_data),
      .busy_o(busy));

   int unsigned n_chk = 0, n_bad = 0;
   int unsigned cyc = 0;
   ent_t q[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic int unsigned hd_exp(input logic [7:0] h);
      return (h == 8'd0) ? 1 : int'(h);
   endfunction

   function automatic logic [15:0] fmt(input logic w, input logic [15:0] v);
      return w ? v : {8'h00, v[7:0]};
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // monitor and slave model, evaluated away from the active edge
   logic p_sck = 1'b0, p_busy = 1'b0, first = 1'b0;
   int unsigned last_edge = 0, busy_start = 0, bitn = 0;
   logic [15:0] cap = '0;
   ent_t cur;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && !p_busy) begin
            busy_start = cyc;
            first = 1'b1;
         end
         if (done) begin
            chk(cyc - last_edge == hd_exp(half_div), "R7 done delay", cyc - last_edge, hd_exp(half_div));
            chk(bitn == (cur.w ? 16 : 8), "R4 bit count", bitn, cur.w ? 16 : 8);
            chk(rd_data == fmt(cur.w, cur.sw), "R3 R4 rx word", rd_data, fmt(cur.w, cur.sw));
            chk(fmt(cur.w, cap) == fmt(cur.w, cur.d), "R3 R4 tx word", cap, fmt(cur.w, cur.d));
            if (q.size() > 0) void'(q.pop_front());
            bitn = 0;
            if (q.size() > 0) begin
               chk(sck && busy, "R8 chained edge", {sck, busy}, 2'b11);
               chk(ss_n == !ss_en, "R8 select held", ss_n, !ss_en);
            end else begin
               chk(!sck && !busy && ss_n, "R11 release", {sck, busy, ss_n}, 3'b001);
            end
         end
         if (sck && !p_sck) begin
            if (first) chk(cyc - busy_start == hd_exp(half_div), "R6 lead delay", cyc - busy_start, hd_exp(half_div));
            else       chk(cyc - last_edge == hd_exp(half_div), "R2 R8 rise spacing", cyc - last_edge, hd_exp(half_div));
            first = 1'b0;
            chk(ss_n == !ss_en, "R5 select level", ss_n, !ss_en);
            if (bitn == 0) begin
               cur = q[0];
               cap = '0;
            end
            cap  = {cap[14:0], mosi};
            miso = cur.sw[(cur.w ? 15 : 7) - bitn];
            bitn++;
            last_edge = cyc;
         end
         if (!sck && p_sck) begin
            chk(cyc - last_edge == hd_exp(half_div), "R2 fall spacing", cyc - last_edge, hd_exp(half_div));
            last_edge = cyc;
         end
         p_sck  = sck;
         p_busy = busy;
      end
   end

   task automatic push(input logic [15:0] d, input logic w, input logic [15:0] sw);
      ent_t e;
      while (!tx_empty) @(negedge clk);
      e.w = w; e.d = d; e.sw = sw;
      q.push_back(e);
      wr_valid = 1'b1; wr_wide = w; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      chk(tx_empty == 1'b0, "R9 write clears empty", tx_empty, 0);
   endtask

   task automatic wait_idle();
      while (q.size() != 0 || busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] pool [4];
      pool[0] = 8'd1; pool[1] = 8'd2; pool[2] = 8'd0; pool[3] = 8'd5;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!sck && !done && ss_n && tx_empty && !busy, "R1 reset",
          {sck, done, ss_n, tx_empty, busy}, 5'b00110);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: ignored write while full (R10), 16 then 8 bit
      half_div = 8'd3; ss_en = 1'b1;
      push(16'hA5C3, 1'b1, 16'h1234);
      push(16'h00F0, 1'b0, 16'h0081);
      @(negedge clk);
      wr_valid = 1'b1; wr_wide = 1'b1; wr_data = 16'hDEAD;
      @(negedge clk);
      wr_valid = 1'b0;
      chk(tx_empty == 1'b0, "R10 full after ignored write", tx_empty, 0);
      wait_idle();

      // directed: select disabled
      ss_en = 1'b0; half_div = 8'd1;
      push(16'h8001, 1'b1, 16'hFFFF);
      push(16'h007E, 1'b0, 16'h0000);
      wait_idle();

      // random bursts
      for (int b = 0; b < 40; b++) begin
         int unsigned nw;
         half_div = pool[$urandom % 4];
         ss_en    = 1'($urandom % 4 != 0);
         nw       = 1 + ($urandom % 4);
         for (int k = 0; k < int'(nw); k++)
            push(16'($urandom), 1'($urandom), 16'($urandom));
         wait_idle();
         chk(ss_n && !sck && tx_empty, "R11 idle after burst", {ss_n, sck, tx_empty}, 3'b101);
      end
      finish_run();
   end
endmodule